// File: doc/BRIEF.md
# Open-Drain Bus Bit-Slot Timer

This block produces one timed bit slot at a time on a single-wire open-drain bus of the kind used by small serial sensors and ID chips. A higher-level sequencer presents a two-bit command together with a one-cycle start pulse. The block then runs a reset/presence slot, a read slot, or a write slot for a 0 or a 1. It drives an output-enable and a data line toward an external pad cell, and it reads the bus back through a two-flop synchronised input. It hands back one result bit and a ready flag.

All phase lengths are parameters in microseconds. A clock-cycles-per-microsecond parameter sets a prescaler. The prescaler runs freely but is realigned to the cycle in which a slot is accepted, so every phase lasts an exact whole number of microseconds. Every phase counter advances only on the microsecond tick.

The state machine has five states:
- `ST_IDLE` waits for start.
- `ST_RST_LOW` holds the bus low for a reset.
- `ST_RST_REL` releases the bus and waits for presence.
- `ST_SLOT_LOW` holds the bus low at the start of a read or write slot.
- `ST_SLOT_REL` releases the bus for the rest of a read or write slot.

Its transitions are:
- idle to reset-low on a reset command.
- idle to slot-low on a read or write command.
- reset-low to reset-release when the low time expires.
- reset-release to idle when the release time expires.
- slot-low to slot-release when the command's low time expires.
- slot-release to idle when the total slot time expires.

Top module: `bus_slot_gen`

## Requirements
- R1: Command decode on `cmd`: 2'b00 starts a reset slot, 2'b01 starts a read slot, 2'b10 writes a 0 and 2'b11 writes a 1. The low bit of a write command is the data bit.
- R2: A reset slot drives the bus low (`oe`=1) for RST_LOW_US microseconds. It then releases the bus for RST_REL_US microseconds, so `valid` stays low for the sum of the two.
- R3: In a reset slot, the synchronised line is captured RST_SAMPLE_US microseconds after release and returned on `result_bit`. A 0 means a device answered.
- R4: A write-0 slot drives the bus low for WR0_LOW_US microseconds. A write-1 slot drives it low for WR1_LOW_US microseconds.
- R5: A read slot drives the bus low for RD_LOW_US microseconds. The synchronised line is captured RD_SAMPLE_US microseconds after the slot was accepted and is returned on `result_bit`.
- R6: Every read or write slot keeps `valid` low for exactly SLOT_US microseconds.
- R7: `valid` is high in idle. It falls in the cycle after the edge that accepts start, and it rises when the slot has ended with `result_bit` settled.
- R8: `din` passes two flip-flops. A capture edge sees the value that `din` held at the clock edge two cycles earlier.
- R9: A start pulse that arrives while a slot is running is ignored. The slot keeps its command and its timing.
- R10: Write slots leave `result_bit` unchanged, whatever the line does.
- R11: An active-low asynchronous reset returns the block to idle with `oe`=0, `valid`=1 and `result_bit`=0.
- R12: `dout` is always 0. The bus is only ever pulled low or released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd | input | 2 | Slot command, sampled with start |
| start | input | 1 | Request pulse, accepted only in idle |
| din | input | 1 | Bus level from the pad cell |
| oe | output | 1 | Pad output enable; high pulls the bus low |
| dout | output | 1 | Pad data, held at 0 |
| valid | output | 1 | High when idle and the result is ready |
| result_bit | output | 1 | Presence or read result |

## Verification
The bench builds the block with four clocks per microsecond and shortened phases: 20/6/20 us for the reset slot, 10 and 2 us for the write lows, a 1 us read low with a 3 us read sample, and a 12 us slot. These short phases let every slot type run many times within a few thousand cycles. Because the prescaler is realigned, each phase length can be counted to the exact clock cycle. A slave model pulls the line in windows that begin or end one cycle on either side of the capture point, which fixes the sample timing through the synchroniser to the cycle.

// File: rtl/slot_pkg.sv
package slot_pkg;

    typedef enum logic [1:0] {
        CMD_RESET = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WR0   = 2'b10,
        CMD_WR1   = 2'b11
    } slot_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_LOW,
        ST_RST_REL,
        ST_SLOT_LOW,
        ST_SLOT_REL
    } slot_state_e;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/slot_us_tick.sv
// Microsecond tick prescaler; realigned when a slot is accepted.
module slot_us_tick #(
    parameter int unsigned CLKS_PER_US = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic align,
    output logic tick
);
    localparam int unsigned PW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLKS_PER_US - 1);

    logic [PW-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_q <= '0;
        else if (align || div_q == LAST)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end

    assign tick = (div_q == LAST);
endmodule

// File: rtl/slot_line_sync.sv
// Synchroniser chain for the bus input; idle level is high.
module slot_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_out
);
    logic [STAGES-1:0] stg_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[0] <= 1'b1;
                else        stg_q[0] <= line_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[i] <= 1'b1;
                else        stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign line_out = stg_q[STAGES-1];
endmodule

// File: rtl/slot_us_counter.sv
// Microsecond phase counter, advancing on the tick only.
module slot_us_counter #(
    parameter int unsigned W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         tick,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (clear)
            count <= '0;
        else if (tick)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/bus_slot_gen.sv
module bus_slot_gen
    import slot_pkg::*;
#(
    parameter int unsigned CLKS_PER_US   = 50,
    parameter int unsigned RST_LOW_US    = 512,
    parameter int unsigned RST_SAMPLE_US = 80,
    parameter int unsigned RST_REL_US    = 512,
    parameter int unsigned WR0_LOW_US    = 80,
    parameter int unsigned WR1_LOW_US    = 8,
    parameter int unsigned RD_LOW_US     = 2,
    parameter int unsigned RD_SAMPLE_US  = 8,
    parameter int unsigned SLOT_US       = 90,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cmd,
    input  logic       start,
    input  logic       din,
    output logic       oe,
    output logic       dout,
    output logic       valid,
    output logic       result_bit
);
    localparam int unsigned MAX_US = umax(umax(umax(RST_LOW_US, RST_REL_US), SLOT_US),
                                          umax(RST_SAMPLE_US, RD_SAMPLE_US));
    localparam int unsigned US_W   = $clog2(MAX_US + 1);

    localparam logic [US_W-1:0] LIM_RST_LOW = US_W'(RST_LOW_US - 1);
    localparam logic [US_W-1:0] LIM_RST_REL = US_W'(RST_REL_US - 1);
    localparam logic [US_W-1:0] LIM_RST_SMP = US_W'(RST_SAMPLE_US - 1);
    localparam logic [US_W-1:0] LIM_WR0     = US_W'(WR0_LOW_US - 1);
    localparam logic [US_W-1:0] LIM_WR1     = US_W'(WR1_LOW_US - 1);
    localparam logic [US_W-1:0] LIM_RD_LOW  = US_W'(RD_LOW_US - 1);
    localparam logic [US_W-1:0] LIM_RD_SMP  = US_W'(RD_SAMPLE_US - 1);
    localparam logic [US_W-1:0] LIM_SLOT    = US_W'(SLOT_US - 1);

    slot_state_e     state_q, state_d;
    slot_cmd_e       cmd_q;
    logic            res_q;
    logic            accept;
    logic            tick;
    logic            timer_clear;
    logic [US_W-1:0] us_cnt;
    logic [US_W-1:0] low_lim;
    logic            line_s;
    logic            rst_capture;
    logic            rd_capture;
    logic            slot_busy;

    slot_us_tick #(.CLKS_PER_US(CLKS_PER_US)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .align (accept),
        .tick  (tick)
    );

    slot_us_counter #(.W(US_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (timer_clear),
        .tick  (tick),
        .count (us_cnt)
    );

    slot_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (din),
        .line_out (line_s)
    );

    assign accept    = (state_q == ST_IDLE) && start;
    assign slot_busy = (state_q == ST_SLOT_LOW) || (state_q == ST_SLOT_REL);

    // Low-phase length of the latched read/write command
    always_comb begin
        unique case (cmd_q)
            CMD_READ:  low_lim = LIM_RD_LOW;
            CMD_WR0:   low_lim = LIM_WR0;
            CMD_WR1:   low_lim = LIM_WR1;
            default:   low_lim = LIM_RD_LOW;
        endcase
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (slot_cmd_e'(cmd) == CMD_RESET) state_d = ST_RST_LOW;
                    else                               state_d = ST_SLOT_LOW;
                end
            end
            ST_RST_LOW:  if (tick && us_cnt == LIM_RST_LOW) state_d = ST_RST_REL;
            ST_RST_REL:  if (tick && us_cnt == LIM_RST_REL) state_d = ST_IDLE;
            ST_SLOT_LOW: if (tick && us_cnt == low_lim)     state_d = ST_SLOT_REL;
            ST_SLOT_REL: if (tick && us_cnt == LIM_SLOT)    state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    assign timer_clear = accept || ((state_q == ST_RST_LOW) && (state_d == ST_RST_REL));
    assign rst_capture = (state_q == ST_RST_REL) && tick && (us_cnt == LIM_RST_SMP);
    assign rd_capture  = slot_busy && (cmd_q == CMD_READ) && tick && (us_cnt == LIM_RD_SMP);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Command latch and result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= CMD_READ;
            res_q <= 1'b0;
        end else begin
            if (accept)                     cmd_q <= slot_cmd_e'(cmd);
            if (rst_capture || rd_capture)  res_q <= line_s;
        end
    end

    // Outputs
    always_comb begin
        oe    = 1'b0;
        valid = 1'b0;
        unique case (state_q)
            ST_IDLE:     valid = 1'b1;
            ST_RST_LOW:  oe    = 1'b1;
            ST_SLOT_LOW: oe    = 1'b1;
            ST_RST_REL,
            ST_SLOT_REL: oe    = 1'b0;
            default:     valid = 1'b1;
        endcase
    end

    assign dout       = 1'b0;
    assign result_bit = res_q;
endmodule

// File: rtl/bus_slot_gen_chk.sv
module bus_slot_gen_chk #(
    parameter int unsigned SLOT_US = 90,
    parameter int unsigned US_W    = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            valid,
    input logic            oe,
    input logic            result_bit,
    input logic [1:0]      cmd_q,
    input logic [US_W-1:0] us_cnt,
    input logic            slot_busy
);
    localparam logic [US_W-1:0] SLOT_V = US_W'(SLOT_US);

    // R7: accepted start drops valid on the next cycle
    assert_valid_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && start) |=> !valid);

    // R9: the latched command holds while a slot runs
    assert_cmd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid) |=> (valid || $stable(cmd_q)));

    // R10: write slots never change the result
    assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && cmd_q[1]) |=> $stable(result_bit));

    // R6: slot timer never passes the total slot length
    assert_slot_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        slot_busy |-> (us_cnt < SLOT_V));

    // R11: idle means bus released
    assert_idle_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> !oe);
endmodule

bind bus_slot_gen bus_slot_gen_chk #(.SLOT_US(SLOT_US), .US_W(US_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .valid      (valid),
    .oe         (oe),
    .result_bit (result_bit),
    .cmd_q      (cmd_q),
    .us_cnt     (us_cnt),
    .slot_busy  (slot_busy)
);

// File: tb/bus_slot_gen_tb.sv
`timescale 1ns/1ps
module bus_slot_gen_tb_top;
    localparam int C    = 4;
    localparam int RL   = 20, RS = 6, RR = 20;
    localparam int W0   = 10, W1 = 2, RDL = 1, RDS = 3, SL = 12;

    localparam int OE_RST = RL * C,  BUSY_RST = (RL + RR) * C;
    localparam int OE_RD  = RDL * C, OE_W0 = W0 * C, OE_W1 = W1 * C;
    localparam int BUSY_SL = SL * C;
    // din set at negedge c is seen by the capture edge K when c = K-3 (R8)
    localparam int RD_C   = RDS * C - 3;
    localparam int RST_C  = (RL + RS) * C - 3;

    typedef struct packed {
        logic [1:0] cmd;
        int         lo_from;
        int         lo_to;
        int         exp_oe;
        int         exp_busy;
        logic       exp_res;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{2'b01, 0, 0, OE_RD, BUSY_SL, 1'b1},                      // R5 no slave
        '{2'b10, 0, 0, OE_W0, BUSY_SL, 1'b1},                      // R4 R10
        '{2'b00, OE_RST + 5, 400, OE_RST, BUSY_RST, 1'b0},         // R3 present
        '{2'b11, 0, 0, OE_W1, BUSY_SL, 1'b0},                      // R4 R10
        '{2'b01, 0, RD_C + 1, OE_RD, BUSY_SL, 1'b0},               // R8 edge
        '{2'b01, 0, RD_C, OE_RD, BUSY_SL, 1'b1},                   // R8 edge
        '{2'b01, RD_C, 400, OE_RD, BUSY_SL, 1'b0},                 // R8 edge
        '{2'b01, RD_C + 1, 400, OE_RD, BUSY_SL, 1'b1},             // R8 edge
        '{2'b00, 0, 0, OE_RST, BUSY_RST, 1'b1},                    // R3 absent
        '{2'b10, 0, 400, OE_W0, BUSY_SL, 1'b1},                    // R10 line low
        '{2'b00, RST_C, RST_C + 1, OE_RST, BUSY_RST, 1'b0},        // R3 R8 edge
        '{2'b11, 0, 0, OE_W1, BUSY_SL, 1'b0}                       // R1 R10
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cmd_i = 2'b00;
    logic       start_i = 1'b0;
    logic       din_i = 1'b1;
    logic       oe, dout, valid, result_bit;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    bus_slot_gen #(
        .CLKS_PER_US(C), .RST_LOW_US(RL), .RST_SAMPLE_US(RS), .RST_REL_US(RR),
        .WR0_LOW_US(W0), .WR1_LOW_US(W1), .RD_LOW_US(RDL), .RD_SAMPLE_US(RDS),
        .SLOT_US(SL)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd(cmd_i), .start(start_i), .din(din_i),
        .oe(oe), .dout(dout), .valid(valid), .result_bit(result_bit)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    // Runs one slot; returns cycles with oe high, cycles with valid low and dout-high count
    task automatic run_slot(input logic [1:0] c_cmd, input int lo_from, input int lo_to,
                            input int extra_at, input logic [1:0] extra_cmd,
                            output int oe_cyc, output int busy_cyc, output int dout_hi);
        int c;
        oe_cyc = 0; busy_cyc = 0; dout_hi = 0;
        @(negedge clk);
        cmd_i = c_cmd; start_i = 1'b1; din_i = 1'b1;
        @(negedge clk);
        c = 0;
        while (!valid && c < 4000) begin
            busy_cyc++;
            if (oe)   oe_cyc++;
            if (dout) dout_hi++;
            din_i = !(oe || (c >= lo_from && c < lo_to));
            if (c == extra_at) begin
                start_i = 1'b1; cmd_i = extra_cmd;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            c++;
        end
        start_i = 1'b0;
        din_i = 1'b1;
        if (c >= 4000) check("slot hang", c, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check("watchdog", 1, 0);
        finish_run();
    end

    initial begin
        int oc, bc, dh;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 valid in reset", int'(valid), 1);
        check("R11 oe in reset", int'(oe), 0);
        check("R11 result in reset", int'(result_bit), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R7 valid idle", int'(valid), 1);

        // Vector table (R1..R6, R8, R10, R12)
        foreach (VECS[i]) begin
            run_slot(VECS[i].cmd, VECS[i].lo_from, VECS[i].lo_to, -1, 2'b00, oc, bc, dh);
            check($sformatf("R1 R2 R4 R5 oe length vec %0d", i), oc, VECS[i].exp_oe);
            check($sformatf("R2 R6 R7 busy length vec %0d", i), bc, VECS[i].exp_busy);
            check($sformatf("R3 R5 R8 R10 result vec %0d", i), int'(result_bit), int'(VECS[i].exp_res));
            check($sformatf("R12 dout vec %0d", i), dh, 0);
        end

        // R9: start during a reset slot is ignored
        run_slot(2'b00, 0, 0, 30, 2'b01, oc, bc, dh);
        check("R9 oe length with extra start", oc, OE_RST);
        check("R9 busy length with extra start", bc, BUSY_RST);
        check("R9 result with extra start", int'(result_bit), 1);
        // R9: start during a write slot ignored, write keeps result (R10)
        run_slot(2'b11, 0, 0, 5, 2'b00, oc, bc, dh);
        check("R9 write busy with extra start", bc, BUSY_SL);
        check("R9 write oe with extra start", oc, OE_W1);
        repeat (3) @(negedge clk);
        check("R9 idle after slot", int'(valid), 1);

        // R7: valid falls one cycle after accepting edge
        @(negedge clk);
        cmd_i = 2'b01; start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        check("R7 valid low after accept", int'(valid), 0);
        check("R5 oe high at read start", int'(oe), 1);
        while (!valid) @(negedge clk);

        // R11: asynchronous reset mid-slot clears the result
        check("R11 result before reset", int'(result_bit), 1);
        @(negedge clk);
        cmd_i = 2'b10; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R11 valid after async reset", int'(valid), 1);
        check("R11 oe after async reset", int'(oe), 0);
        check("R11 result after async reset", int'(result_bit), 0);
        @(negedge clk);
        rst_n = 1'b1;
        run_slot(2'b01, 0, 0, -1, 2'b00, oc, bc, dh);
        check("R5 read after reset", int'(result_bit), 1);
        check("R6 busy after reset", bc, BUSY_SL);

        finish_run();
    end
endmodule